// File: doc/BRIEF.md
# Protection Unit Region Configuration Register File

This block holds the software-visible configuration of a region-based memory protection unit with sixteen regions. A processor-side bus writes and reads 32-bit words at byte offsets. The bank holds a read-only capability word, a control word with three enable bits, a region selector, and a base word and an attribute word for each region. The base and attribute registers at the main offsets act on the region named by the selector. Three further offset pairs act on that same region in the same way.

A base write can carry its own region number and a flag. When the flag is set, the write goes to the named region and the selector moves to that region, so software can fill the whole table with base and attribute writes alone. The stored configuration of every region, and the control bits, leave the block as plain level outputs for the address-check logic next to it.

The bus side is a request/response stream. A request (`bus_valid`) is accepted in every cycle, so there is no back-pressure and no ready signal. A read request returns `rsp_valid` with `rsp_rdata` one cycle later. Writes return no response.

Top module: `mpr_regfile`

## Requirements
- R1: After reset the control bits are 0, the selector reads 0, and every region's base and attribute words are 0, so all regions are disabled.
- R2: Offset 0x000 reads 0x0000_1000: the region count (16) sits in bits [15:8] and all other bits are zero. A write to it changes nothing.
- R3: Offset 0x004 stores only bits [2:0]: bit 2 drives `priv_bg`, bit 1 drives `fault_enf` and bit 0 drives `mpu_on`. Its reads return those three bits with all other bits zero.
- R4: Offset 0x008 stores and reads back an 8-bit selector in bits [7:0], with all other bits zero.
- R5: A base write (offsets 0x00C, 0x014, 0x01C, 0x024) with bit 4 clear stores bits [31:5] into the region named by the selector. Base reads return that value with bits [4:0] zero.
- R6: A base write with bit 4 set loads the selector with bits [3:0], zero-extended, and stores bits [31:5] into that region, whatever the selector held before.
- R7: An attribute write (offsets 0x010, 0x018, 0x020, 0x028) keeps only the bits under mask 0x173F_FF3F. These are bit 28, bits [26:24], bits [21:16], bits [15:8], bits [5:1] and bit 0 (region enable). All other bits read as zero.
- R8: All four base offsets reach the same storage for the selected region, and so do all four attribute offsets.
- R9: While the selector holds 16 or more, base and attribute reads return zero, and base writes with bit 4 clear and attribute writes store nothing.
- R10: A read returns `rsp_valid` high one cycle after the request, with data taken from the state before that edge. `rsp_valid` is low in every other cycle. Unaligned offsets and offsets above 0x028 read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Request present this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| mpu_on | output | 1 | Global protection enable |
| fault_enf | output | 1 | Enforce regions in high-priority fault handlers |
| priv_bg | output | 1 | Default map as privileged background |
| region_base_o | output | 512 | Base word of region n at bits [32n+31:32n] |
| region_attr_o | output | 512 | Attribute word of region n at bits [32n+31:32n] |

## Verification
The region outputs and control pins are compared with the reference model on every cycle. A base or attribute word stored in the wrong region, or with reserved bits kept, therefore shows up one cycle after the write that caused it. A selector that is wrong after a redirecting base write shows only through later traffic: the next read of the selector, or of a base or attribute register, returns the wrong value one cycle after that read. Stores made while the selector is out of range are caught the same way, because the whole region vector is compared after each write.

// File: rtl/mpr_pkg.sv
package mpr_pkg;
  localparam int DATA_W         = 32;
  localparam int FLAG_BIT       = 4;   // base write: redirect flag
  localparam int REGION_FIELD_W = 4;   // base write: region number width
  localparam int BASE_LSB       = 5;
  localparam int COUNT_LSB      = 8;   // capability: region count position
  localparam int CTRL_W         = 3;
  localparam logic [DATA_W-1:0] ATTR_KEEP = 32'h173F_FF3F;

  typedef struct packed {
    logic cap;
    logic ctrl;
    logic sel;
    logic base;
    logic attr;
  } reg_hit_t;

  function automatic reg_hit_t decode_word(input int unsigned w);
    reg_hit_t h;
    h = '0;
    if (w == 0) h.cap = 1'b1;
    else if (w == 1) h.ctrl = 1'b1;
    else if (w == 2) h.sel = 1'b1;
    else if (w >= 3 && w <= 10) begin
      h.base = w[0];
      h.attr = ~w[0];
    end
    return h;
  endfunction
endpackage

// File: rtl/mpr_decode.sv
module mpr_decode
  import mpr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_hit_t          hit
);
  always_comb begin
    if (addr[1:0] != 2'b00) hit = '0;
    else hit = decode_word(32'(addr[ADDR_W-1:2]));
  end
endmodule

// File: rtl/mpr_sel_ctrl.sv
module mpr_sel_ctrl
  import mpr_pkg::*;
#(
  parameter int SEL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic              sel_we,
  input  logic              base_we,
  input  logic [SEL_W-1:0]  wd_lo,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [SEL_W-1:0]  sel_q,
  output logic [SEL_W-1:0]  tgt
);
  logic redirect;

  always_comb begin
    redirect = base_we & wd_lo[FLAG_BIT];
    tgt = redirect ? SEL_W'(wd_lo[REGION_FIELD_W-1:0]) : sel_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      sel_q  <= '0;
    end else begin
      if (ctrl_we) ctrl_q <= wd_lo[CTRL_W-1:0];
      if (sel_we) sel_q <= wd_lo;
      else if (redirect) sel_q <= tgt;
    end
  end
endmodule

// File: rtl/mpr_region_bank.sv
module mpr_region_bank
  import mpr_pkg::*;
#(
  parameter int NUM_REGIONS = 16,
  parameter int SEL_W       = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          base_we,
  input  logic                          attr_we,
  input  logic [SEL_W-1:0]              tgt,
  input  logic [DATA_W-1:0]             wdata,
  input  logic [SEL_W-1:0]              rd_idx,
  output logic [NUM_REGIONS*DATA_W-1:0] base_flat,
  output logic [NUM_REGIONS*DATA_W-1:0] attr_flat,
  output logic [DATA_W-1:0]             base_rd,
  output logic [DATA_W-1:0]             attr_rd
);
  localparam int IDX_W  = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1;
  localparam int BASE_W = DATA_W - BASE_LSB;

  logic [BASE_W-1:0] base_q [NUM_REGIONS];
  logic [DATA_W-1:0] attr_q [NUM_REGIONS];
  logic              rd_ok;

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
    logic hit_g;
    assign hit_g = (tgt == SEL_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q[g] <= '0;
        attr_q[g] <= '0;
      end else begin
        if (base_we && hit_g) base_q[g] <= wdata[DATA_W-1:BASE_LSB];
        if (attr_we && hit_g) attr_q[g] <= wdata & ATTR_KEEP;
      end
    end
    assign base_flat[g*DATA_W +: DATA_W] = {base_q[g], {BASE_LSB{1'b0}}};
    assign attr_flat[g*DATA_W +: DATA_W] = attr_q[g];
  end

  always_comb begin
    rd_ok   = (32'(rd_idx) < 32'(NUM_REGIONS));
    base_rd = rd_ok ? {base_q[rd_idx[IDX_W-1:0]], {BASE_LSB{1'b0}}} : '0;
    attr_rd = rd_ok ? attr_q[rd_idx[IDX_W-1:0]] : '0;
  end
endmodule

// File: rtl/mpr_regfile.sv
module mpr_regfile
  import mpr_pkg::*;
#(
  parameter int NUM_REGIONS = 16,
  parameter int ADDR_W      = 8,
  parameter int SEL_W       = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bus_valid,
  input  logic                          bus_write,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic [31:0]                   bus_wdata,
  output logic                          rsp_valid,
  output logic [31:0]                   rsp_rdata,
  output logic                          mpu_on,
  output logic                          fault_enf,
  output logic                          priv_bg,
  output logic [NUM_REGIONS*32-1:0]     region_base_o,
  output logic [NUM_REGIONS*32-1:0]     region_attr_o
);
  reg_hit_t          hit;
  logic              wr, rd;
  logic [CTRL_W-1:0] ctrl_q;
  logic [SEL_W-1:0]  sel_q, tgt;
  logic [DATA_W-1:0] base_rd, attr_rd, rd_mux;

  mpr_decode #(.ADDR_W(ADDR_W)) u_dec (.addr(bus_addr), .hit(hit));

  assign wr = bus_valid & bus_write;
  assign rd = bus_valid & ~bus_write;

  mpr_sel_ctrl #(.SEL_W(SEL_W)) u_sel (
    .clk(clk), .rst_n(rst_n),
    .ctrl_we(wr & hit.ctrl), .sel_we(wr & hit.sel), .base_we(wr & hit.base),
    .wd_lo(bus_wdata[SEL_W-1:0]),
    .ctrl_q(ctrl_q), .sel_q(sel_q), .tgt(tgt)
  );

  mpr_region_bank #(.NUM_REGIONS(NUM_REGIONS), .SEL_W(SEL_W)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .base_we(wr & hit.base), .attr_we(wr & hit.attr),
    .tgt(tgt), .wdata(bus_wdata), .rd_idx(sel_q),
    .base_flat(region_base_o), .attr_flat(region_attr_o),
    .base_rd(base_rd), .attr_rd(attr_rd)
  );

  always_comb begin
    rd_mux = '0;
    if (hit.cap)  rd_mux = DATA_W'(NUM_REGIONS) << COUNT_LSB;
    if (hit.ctrl) rd_mux = DATA_W'(ctrl_q);
    if (hit.sel)  rd_mux = DATA_W'(sel_q);
    if (hit.base) rd_mux = base_rd;
    if (hit.attr) rd_mux = attr_rd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd;
      if (rd) rsp_rdata <= rd_mux;
    end
  end

  assign mpu_on    = ctrl_q[0];
  assign fault_enf = ctrl_q[1];
  assign priv_bg   = ctrl_q[2];
endmodule

// File: rtl/mpr_regfile_chk.sv
module mpr_regfile_chk #(
  parameter int NUM_REGIONS = 16,
  parameter int ADDR_W      = 8,
  parameter int SEL_W       = 8
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      bus_valid,
  input logic                      bus_write,
  input logic [ADDR_W-1:0]         bus_addr,
  input logic [31:0]               bus_wdata,
  input logic                      rsp_valid,
  input logic [31:0]               rsp_rdata,
  input logic                      mpu_on,
  input logic                      fault_enf,
  input logic                      priv_bg,
  input logic [NUM_REGIONS*32-1:0] region_base_o,
  input logic [NUM_REGIONS*32-1:0] region_attr_o,
  input logic [SEL_W-1:0]          sel_q
);
  localparam int IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1;

  logic        aligned, is_base, is_attr, sel_in_range;
  int unsigned word;
  logic [31:0] sel_base;

  always_comb begin
    aligned      = (bus_addr[1:0] == 2'b00);
    word         = 32'(bus_addr[ADDR_W-1:2]);
    is_base      = aligned && word >= 3 && word <= 9 && word[0];
    is_attr      = aligned && word >= 4 && word <= 10 && !word[0];
    sel_in_range = 32'(sel_q) < 32'(NUM_REGIONS);
    sel_base     = region_base_o[32'(sel_q[IDX_W-1:0])*32 +: 32];
  end

  a_r10_rsp_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write) |=> rsp_valid);
  a_r10_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && !bus_write) |=> !rsp_valid);
  a_r2_cap_value: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && bus_addr == '0) |=> rsp_rdata == (32'(NUM_REGIONS) << 8));
  a_r3_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && aligned && word == 1) |=>
      {priv_bg, fault_enf, mpu_on} == $past(bus_wdata[2:0]));
  a_r6_redirect_sel: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && is_base && bus_wdata[4]) |=>
      sel_q == SEL_W'($past(bus_wdata[3:0])));
  a_r5_base_store: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && is_base && !bus_wdata[4] && sel_in_range) |=>
      sel_base == {$past(bus_wdata[31:5]), 5'b0});
  a_r9_oob_no_store: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && ((is_base && !bus_wdata[4]) || is_attr) && !sel_in_range) |=>
      ($stable(region_base_o) && $stable(region_attr_o)));

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_chk
    a_r7_attr_reserved: assert property (@(posedge clk) disable iff (!rst_n)
      (region_attr_o[g*32 +: 32] & ~32'h173F_FF3F) == 32'h0);
  end
endmodule

bind mpr_regfile mpr_regfile_chk #(
  .NUM_REGIONS(NUM_REGIONS), .ADDR_W(ADDR_W), .SEL_W(SEL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rsp_valid(rsp_valid),
  .rsp_rdata(rsp_rdata), .mpu_on(mpu_on), .fault_enf(fault_enf), .priv_bg(priv_bg),
  .region_base_o(region_base_o), .region_attr_o(region_attr_o), .sel_q(sel_q)
);

// File: tb/mpr_regfile_test.sv
module mpr_regfile_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_valid = 1'b0;
  logic         bus_write = 1'b0;
  logic [7:0]   bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic         rsp_valid, mpu_on, fault_enf, priv_bg;
  logic [31:0]  rsp_rdata;
  logic [511:0] region_base_o, region_attr_o;

  int errs = 0;
  int checks = 0;

  // reference model
  logic [31:0] m_base [16];
  logic [31:0] m_attr [16];
  logic [2:0]  m_ctrl;
  logic [7:0]  m_sel;

  mpr_regfile uut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .mpu_on(mpu_on), .fault_enf(fault_enf), .priv_bg(priv_bg),
    .region_base_o(region_base_o), .region_attr_o(region_attr_o)
  );

  always #4 clk = ~clk;

  function automatic bit is_base_off(input logic [7:0] a);
    return a == 8'h0C || a == 8'h14 || a == 8'h1C || a == 8'h24;
  endfunction
  function automatic bit is_attr_off(input logic [7:0] a);
    return a == 8'h10 || a == 8'h18 || a == 8'h20 || a == 8'h28;
  endfunction

  function automatic logic [31:0] m_read(input logic [7:0] a);
    if (a == 8'h00) return 32'h0000_1000;
    if (a == 8'h04) return {29'b0, m_ctrl};
    if (a == 8'h08) return {24'b0, m_sel};
    if (is_base_off(a)) return (m_sel < 16) ? m_base[m_sel[3:0]] : 32'h0;
    if (is_attr_off(a)) return (m_sel < 16) ? m_attr[m_sel[3:0]] : 32'h0;
    return 32'h0;
  endfunction

  task automatic m_write(input logic [7:0] a, input logic [31:0] d);
    if (a == 8'h04) m_ctrl = d[2:0];
    else if (a == 8'h08) m_sel = d[7:0];
    else if (is_base_off(a)) begin
      if (d[4]) begin
        m_sel = {4'b0, d[3:0]};
        m_base[d[3:0]] = {d[31:5], 5'b0};
      end else if (m_sel < 16) m_base[m_sel[3:0]] = {d[31:5], 5'b0};
    end else if (is_attr_off(a)) begin
      if (m_sel < 16) m_attr[m_sel[3:0]] = d & 32'h173F_FF3F;
    end
  endtask

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(input string tag, input bit exp_v, input logic [31:0] exp_d);
    logic [511:0] eb, ea;
    for (int i = 0; i < 16; i++) begin
      eb[i*32 +: 32] = m_base[i];
      ea[i*32 +: 32] = m_attr[i];
    end
    chk(rsp_valid == exp_v, tag, "rsp_valid", 512'(rsp_valid), 512'(exp_v));
    if (exp_v) chk(rsp_rdata == exp_d, tag, "rsp_rdata", 512'(rsp_rdata), 512'(exp_d));
    chk({priv_bg, fault_enf, mpu_on} == m_ctrl, tag, "ctrl pins",
        512'({priv_bg, fault_enf, mpu_on}), 512'(m_ctrl));
    chk(region_base_o == eb, tag, "region bases", region_base_o, eb);
    chk(region_attr_o == ea, tag, "region attrs", region_attr_o, ea);
  endtask

  // one bus operation: drive at negedge, model updates at the edge, compare at next negedge
  task automatic op(input bit w, input logic [7:0] a, input logic [31:0] d, input string tag);
    logic [31:0] exp_d;
    exp_d = m_read(a);
    bus_valid = 1'b1;
    bus_write = w;
    bus_addr  = a;
    bus_wdata = d;
    @(posedge clk);
    if (w) m_write(a, d);
    @(negedge clk);
    bus_valid = 1'b0;
    compare_all(tag, !w, exp_d);
  endtask

  task automatic idle(input string tag);
    @(negedge clk);
    compare_all(tag, 1'b0, 32'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    $display("FAIL watchdog: actual=timeout expected=finish");
    errs++;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      m_base[i] = '0;
      m_attr[i] = '0;
    end
    m_ctrl = '0;
    m_sel  = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    compare_all("R1", 1'b0, 32'h0);
    op(0, 8'h08, 0, "R1");
    op(0, 8'h04, 0, "R1");
    op(0, 8'h10, 0, "R1");

    op(0, 8'h00, 0, "R2");
    op(1, 8'h00, 32'hFFFF_FFFF, "R2");
    op(0, 8'h00, 0, "R2");

    op(1, 8'h04, 32'hFFFF_FFFF, "R3");
    op(0, 8'h04, 0, "R3");
    op(1, 8'h04, 32'h0000_0005, "R3");
    op(0, 8'h04, 0, "R3");

    op(1, 8'h08, 32'hABCD_EF05, "R4");
    op(0, 8'h08, 0, "R4");

    op(1, 8'h0C, 32'h2000_0123, "R5");
    op(0, 8'h0C, 0, "R5");

    op(1, 8'h0C, 32'h4000_001A, "R6");
    op(0, 8'h08, 0, "R6");
    op(0, 8'h0C, 0, "R6");

    op(1, 8'h10, 32'hFFFF_FFFF, "R7");
    op(0, 8'h10, 0, "R7");
    op(1, 8'h10, 32'h1234_5679, "R7");
    op(0, 8'h10, 0, "R7");

    op(1, 8'h14, 32'h1111_1103, "R8");
    op(0, 8'h0C, 0, "R8");
    op(1, 8'h20, 32'h0600_0A0B, "R8");
    op(0, 8'h18, 0, "R8");
    op(0, 8'h28, 0, "R8");
    op(1, 8'h24, 32'h8000_0013, "R8");
    op(0, 8'h1C, 0, "R8");
    op(1, 8'h18, 32'h0300_0027, "R8");
    op(0, 8'h10, 0, "R8");

    for (int r = 0; r < 16; r++) begin
      op(1, 8'h1C, {8'(r * 17 + 3), 19'h0_1234, 1'b1, 4'(r)}, "R6");
      op(1, 8'h20, 32'hFFFF_FFFF ^ 32'(r << 9), "R7");
    end
    op(0, 8'h08, 0, "R6");

    op(1, 8'h08, 32'h0000_0020, "R9");
    op(0, 8'h0C, 0, "R9");
    op(0, 8'h10, 0, "R9");
    op(1, 8'h0C, 32'hDEAD_BEE0, "R9");
    op(1, 8'h18, 32'hFFFF_FFFF, "R9");
    op(0, 8'h08, 0, "R9");
    op(1, 8'h14, 32'h5555_5557, "R9");
    op(0, 8'h08, 0, "R9");
    op(1, 8'h08, 32'h0000_0010, "R9");
    op(1, 8'h10, 32'h0000_0001, "R9");
    op(0, 8'h24, 0, "R9");

    op(1, 8'h08, 32'h0000_0002, "R10");
    op(0, 8'h2C, 0, "R10");
    op(0, 8'hFC, 0, "R10");
    op(0, 8'h0E, 0, "R10");
    op(1, 8'h0D, 32'hFFFF_FFF0, "R10");
    op(1, 8'h2C, 32'hFFFF_FFFF, "R10");
    op(1, 8'h05, 32'h0000_0007, "R10");
    idle("R10");
    op(0, 8'h0C, 0, "R10");
    op(0, 8'h04, 0, "R10");
    idle("R10");

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule